// File: doc/BRIEF.md
# Frequency-counter test and gate generator

This block drives a frequency-counter exercise with two signals made from the system clock. The test signal is the system clock divided by the parameter `DIV`, with a 50% duty cycle; it plays the part of the unknown input to be measured. The gate clock is slower and marks out the measurement window. Each gate period spans exactly N full test-signal cycles.

N is set by two BCD digits, tens and ones, so N = tens×10 + ones and ranges from 0 to 99. A setting of 0 parks the gate low. The gate is high for the first ceil(N/2) test cycles of each period and low for the rest. Both of its edges fall on the system-clock edge where the test signal rises. The digits are read only when a new gate period begins, so the current window is never cut short or stretched.

Top module: `freq_gate_gen`

## Requirements
- R1: While reset is high, and after reset until the first test-signal rise, `test_sig` and `gate` are both 0.
- R2: `test_sig` first rises on the `DIV`-th rising clock edge after reset is released. It then repeats with a period of `DIV` clocks: high for `DIV/2` clocks, low for the rest.
- R3: The ratio N is tens×10 + ones. Each gate period lasts exactly N test-signal cycles.
- R4: In each period the gate is high for the first ceil(N/2) test cycles and low for the remaining N − ceil(N/2). `gate` changes only on a clock edge where `test_sig` rises.
- R5: With a ratio of 0, `gate` stays low. The digits are then read again at every test-signal rise.
- R6: A BCD digit value of 10 to 15 is treated as 9, so tens=15, ones=12 gives N=99.
- R7: The digits are sampled only at the test-signal rise that starts a gate period. Changes made within a period take effect at the start of the next one.
- R8: With N=1, every test cycle is a whole period, and `gate` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tens_bcd | input | 4 | Tens digit of the ratio (BCD) |
| ones_bcd | input | 4 | Ones digit of the ratio (BCD) |
| test_sig | output | 1 | Divided test signal, 50% duty |
| gate | output | 1 | Gate clock, N test cycles per period |

## Verification
Two functions can land on the same clock edge. A test-signal rise that ends one gate period also reloads the ratio from the digits, and that same edge must start the next gate level. The bench provokes this by changing the digits a few test cycles before a boundary, on the boundary itself, and inside a zero-ratio stretch where every rise is a reload. An independent cycle model sets the expected value of both outputs at each falling edge; it judges whether the new ratio and its gate level appear exactly on that rise and not one cycle early or late.

// File: rtl/fgg_pkg.sv
package fgg_pkg;

    localparam int RATIO_W = 7;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t ratio;     // test cycles per gate period
        ratio_t high_len;  // test cycles with gate high
    } period_cfg_t;

    function automatic logic [3:0] clamp_digit(input logic [3:0] d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction

    function automatic period_cfg_t make_cfg(input logic [3:0] tens, input logic [3:0] ones);
        period_cfg_t c;
        c.ratio    = ratio_t'(clamp_digit(tens)) * ratio_t'(10) + ratio_t'(clamp_digit(ones));
        c.high_len = (c.ratio + ratio_t'(1)) >> 1;
        return c;
    endfunction

endpackage

// File: rtl/fgg_div.sv
module fgg_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic test_q,
    output logic rise
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign rise = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            test_q <= 1'b0;
        end else begin
            cnt <= rise ? '0 : cnt + CW'(1);
            if (rise)
                test_q <= 1'b1;
            else if (cnt == CW'(HALF - 1))
                test_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fgg_seq.sv
module fgg_seq
    import fgg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic [3:0] tens_bcd,
    input  logic [3:0] ones_bcd,
    output logic       gate_q,
    output ratio_t     ratio_act
);
    period_cfg_t cfg, nxt;
    ratio_t      pos;
    logic        start;

    assign nxt       = make_cfg(tens_bcd, ones_bcd);
    assign start     = (cfg.ratio == '0) || (pos == cfg.ratio - ratio_t'(1));
    assign ratio_act = cfg.ratio;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            pos    <= '0;
            gate_q <= 1'b0;
        end else if (rise) begin
            if (start) begin
                cfg    <= nxt;
                pos    <= '0;
                gate_q <= (nxt.ratio != '0);
            end else begin
                pos    <= pos + ratio_t'(1);
                gate_q <= (pos + ratio_t'(1)) < cfg.high_len;
            end
        end
    end
endmodule

// File: rtl/freq_gate_gen.sv
module freq_gate_gen
    import fgg_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] tens_bcd,
    input  logic [3:0] ones_bcd,
    output logic       test_sig,
    output logic       gate
);
    logic   rise;
    ratio_t active_ratio;

    fgg_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst    (rst),
        .test_q (test_sig),
        .rise   (rise)
    );

    fgg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .tens_bcd  (tens_bcd),
        .ones_bcd  (ones_bcd),
        .gate_q    (gate),
        .ratio_act (active_ratio)
    );
endmodule

// File: rtl/fgg_chk.sv
module fgg_chk
    import fgg_pkg::*;
#(
    parameter int DIV = 4
) (
    input logic   clk,
    input logic   rst,
    input logic   test_sig,
    input logic   gate,
    input ratio_t ratio_act
);
    localparam int HALF = DIV / 2;

    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= '0;
        else
            hi_cnt <= test_sig ? hi_cnt + 16'd1 : 16'd0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!test_sig && !gate));

    // R2
    test_high_len_chk: assert property (@(posedge clk) disable iff (rst) hi_cnt <= 16'(HALF));

    // R4
    gate_edge_align_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(gate) |-> $rose(test_sig));

    // R5
    zero_ratio_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio_act == '0) |-> !gate);

    // R6
    ratio_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_act <= ratio_t'(99));
endmodule

bind freq_gate_gen fgg_chk #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .test_sig  (test_sig),
    .gate      (gate),
    .ratio_act (active_ratio)
);

// File: tb/freq_gate_gen_tb.sv
`timescale 1ns/1ps
module freq_gate_gen_tb;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tens_bcd = '0;
    logic [3:0] ones_bcd = '0;
    logic       test_sig, gate;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 0;
    string tag    = "R1";

    // bench model state
    int k = 0;        // edges since reset release
    int m_n = 0;      // active ratio
    int m_idx = 0;    // test cycle within period
    bit exp_test = 0, exp_gate = 0;

    always #5 clk = ~clk;

    freq_gate_gen #(.DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .tens_bcd(tens_bcd), .ones_bcd(ones_bcd),
        .test_sig(test_sig), .gate(gate)
    );

    function automatic int digit_val(input logic [3:0] d);
        return (d > 9) ? 9 : int'(d);
    endfunction

    function automatic int ratio_of(input logic [3:0] t, input logic [3:0] o);
        return digit_val(t) * 10 + digit_val(o);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            k = 0; m_n = 0; m_idx = 0;
            exp_test = 0; exp_gate = 0;
        end else begin
            k = k + 1;
            exp_test = (k >= DIV) && ((k % DIV) < HALF);
            if (k >= DIV && (k % DIV) == 0) begin
                if (m_n == 0 || m_idx == m_n - 1) begin
                    m_n = ratio_of(tens_bcd, ones_bcd);
                    m_idx = 0;
                end else begin
                    m_idx = m_idx + 1;
                end
                exp_gate = (m_n != 0) && (m_idx < (m_n + 1) / 2);
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (test_sig !== exp_test) begin
                errors++;
                $display("FAIL %s test_sig: actual=%0b expected=%0b (k=%0d)",
                         (rst || k < DIV) ? "R1" : "R2", test_sig, exp_test, k);
            end
            checks++;
            if (gate !== exp_gate) begin
                errors++;
                $display("FAIL %s gate: actual=%0b expected=%0b (k=%0d n=%0d idx=%0d)",
                         (rst || k < DIV) ? "R1" : tag, gate, exp_gate, k, m_n, m_idx);
            end
        end
    end

    task automatic wait_tests(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic set_digits(input logic [3:0] t, input logic [3:0] o);
        tens_bcd = t;
        ones_bcd = o;
    endtask

    initial begin
        void'($urandom(32'd2024));
        tag = "R1";
        set_digits(4'd0, 4'd3);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        wait_tests(2);

        tag = "R5";
        set_digits(4'd0, 4'd0);
        wait_tests(10);
        set_digits(4'd0, 4'd4);
        wait_tests(1);
        set_digits(4'd0, 4'd0);
        wait_tests(12);

        tag = "R3 R4";
        set_digits(4'd1, 4'd2);
        wait_tests(40);
        set_digits(4'd0, 4'd7);
        wait_tests(30);

        tag = "R6";
        set_digits(4'd15, 4'd12);
        wait_tests(220);
        set_digits(4'd0, 4'd11);
        wait_tests(25);

        tag = "R7";
        set_digits(4'd0, 4'd8);
        wait_tests(20);
        set_digits(4'd0, 4'd3);
        wait_tests(3);
        set_digits(4'd0, 4'd5);
        wait_tests(1);
        set_digits(4'd0, 4'd2);
        wait_tests(15);

        tag = "R8";
        set_digits(4'd0, 4'd1);
        wait_tests(12);

        tag = "R3 R4 R7";
        for (int i = 0; i < 40; i++) begin
            set_digits(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
            repeat ($urandom_range(1, 60 * DIV)) @(negedge clk);
        end

        tag = "R1";
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wait_tests(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule